// File: doc/BRIEF.md
# Sleep Entry and Wake Recovery Guard

This block sits between a synchronous memory's command sequencer and its array control. It watches an active-high sleep request that may change at any time relative to the clock. When the request stays high, the guard takes the memory into a retained-state sleep after a fixed entry delay. While asleep, it blocks every other input, forces the data outputs off and presents an idle (deselect) command downstream. The array and all internal state are left untouched, so contents survive the sleep.

When the request falls, the guard does not hand control straight back. It opens a recovery window of a parameterised number of clock cycles. During that window deselect and read commands pass through unchanged. Any write is replaced by an idle command and flagged on a reject output. If the request falls again before entry completes, the guard returns to normal operation with no recovery window. The request passes through a flop synchronizer before any decision is taken on it.

Top module: `sleep_gate_ctrl`

## Requirements
- R1: While reset is held low, and after it is released with the request low, asleep_o, in_block_o, out_dis_o and cmd_rej_o are 0 and cmd_o equals cmd_i.
- R2: A request that rises before rising edge k and stays high makes asleep_o go to 1 after edge k+SYNC_STAGES+ENTRY_CYC-1 (edge k+3 with defaults), and not earlier.
- R3: While asleep_o is 1, in_block_o and out_dis_o are 1, cmd_o is idle (2'b00) whatever cmd_i is, and cmd_rej_o stays 0.
- R4: A request that is seen high by the synchronizer for only one cycle never sets asleep_o and opens no recovery window: writes pass unchanged in every following cycle.
- R5: A request that falls before edge j makes asleep_o drop after edge j+SYNC_STAGES (edge j+2 with defaults). A recovery window of exactly REC_CYC cycles follows, after which writes pass again.
- R6: Command encoding on cmd_i and cmd_o is 2'b00 idle/deselect, 2'b01 read, 2'b10 write selected lanes, 2'b11 write all lanes. During recovery, a command with bit 1 set (either write) is replaced by 2'b00 and cmd_rej_o is 1 in that same cycle.
- R7: During recovery, idle (2'b00) and read (2'b01) pass to cmd_o unchanged with cmd_rej_o at 0.
- R8: Outside sleep and recovery, including the entry delay, all four command codes pass to cmd_o unchanged with cmd_rej_o at 0.
- R9: A request that rises again during recovery does not cut the window short. Recovery runs its full REC_CYC cycles, one normal cycle follows, and then the usual entry delay runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Synchronous reset, active low |
| sleep_req_i | input | 1 | Asynchronous sleep request, active high |
| cmd_i | input | 2 | Decoded command from the sequencer |
| cmd_o | output | 2 | Command forwarded to the array control |
| asleep_o | output | 1 | Memory is in sleep |
| in_block_o | output | 1 | All non-sleep inputs are to be ignored |
| out_dis_o | output | 1 | Data outputs are to be held off (high impedance) |
| cmd_rej_o | output | 1 | A write was dropped during recovery this cycle |

## Verification
The request reaches the state machine through SYNC_STAGES flops. Sleep is therefore reported three edges after the first edge that samples a rising request, and wake is reported two edges after the first edge that samples a falling request. The recovery window then lasts exactly REC_CYC cycles. Command filtering and rejection act in the same cycle as cmd_i, because they are combinational from the current state. The driver applies each stimulus on the falling edge and queues the expected values, already offset by these latencies. The monitor compares them 2 ns later, in the low phase before the next rising edge, so that every result is read only after the edge that produces it.

// File: rtl/slp_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the sleep guard.
// Assumes a 2-bit decoded command where bit 1 marks any write.
package slp_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRSEL = 2'b10,
        CMD_WRALL = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        ST_AWAKE   = 2'b00,
        ST_ARMING  = 2'b01,
        ST_ASLEEP  = 2'b10,
        ST_RECOVER = 2'b11
    } slp_state_e;

    function automatic logic is_write(input logic [1:0] c);
        return c[1];
    endfunction

endpackage

// File: rtl/slp_sync.sv
`timescale 1ns/1ps
// Module: slp_sync
// Brings an asynchronous level into the clock domain through STAGES flops.
// Assumes STAGES >= 2. Reset clears the chain so a stale request is not seen.
module slp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage: capture the raw asynchronous level.
                always_ff @(posedge clk_i) begin
                    if (!rst_ni) chain_q[0] <= 1'b0;
                    else         chain_q[0] <= async_i;
                end
            end else begin : g_next
                // Later stages: let metastability settle.
                always_ff @(posedge clk_i) begin
                    if (!rst_ni) chain_q[g] <= 1'b0;
                    else         chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/slp_fsm.sv
`timescale 1ns/1ps
// Module: slp_fsm
// Sequences awake, arming (entry delay), asleep and recovery.
// Assumes ENTRY_CYC >= 2 and REC_CYC >= 1. The request input is already synchronous.
// A request seen high during recovery waits until recovery has finished.
module slp_fsm
    import slp_pkg::*;
#(
    parameter int ENTRY_CYC = 2,
    parameter int REC_CYC   = 3
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_s_i,
    output logic asleep_o,
    output logic recover_o
);

    localparam int MAXC = (ENTRY_CYC > REC_CYC) ? ENTRY_CYC : REC_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] ENTRY_LAST = CW'(ENTRY_CYC - 1);
    localparam logic [CW-1:0] REC_LOAD   = CW'(REC_CYC - 1);

    slp_state_e    st_q;
    logic [CW-1:0] cnt_q;

    // State and shared delay counter update.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q  <= ST_AWAKE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                ST_AWAKE: begin
                    if (req_s_i) begin
                        st_q  <= ST_ARMING;
                        cnt_q <= CW'(1);
                    end
                end
                ST_ARMING: begin
                    if (!req_s_i)                st_q  <= ST_AWAKE;
                    else if (cnt_q >= ENTRY_LAST) st_q  <= ST_ASLEEP;
                    else                          cnt_q <= cnt_q + CW'(1);
                end
                ST_ASLEEP: begin
                    if (!req_s_i) begin
                        st_q  <= ST_RECOVER;
                        cnt_q <= REC_LOAD;
                    end
                end
                default: begin
                    if (cnt_q == '0) st_q  <= ST_AWAKE;
                    else             cnt_q <= cnt_q - CW'(1);
                end
            endcase
        end
    end

    // Decode registered state into phase flags.
    always_comb begin
        asleep_o  = (st_q == ST_ASLEEP);
        recover_o = (st_q == ST_RECOVER);
    end

endmodule

// File: rtl/slp_cmd_filter.sv
`timescale 1ns/1ps
// Module: slp_cmd_filter
// Gates the sequencer command by phase: idle while asleep, writes dropped in recovery.
// Assumes asleep_i and recover_i are never both high.
module slp_cmd_filter
    import slp_pkg::*;
(
    input  logic       asleep_i,
    input  logic       recover_i,
    input  logic [1:0] cmd_i,
    output logic [1:0] cmd_o,
    output logic       rej_o
);

    // Choose the forwarded command and the reject flag.
    always_comb begin
        cmd_o = cmd_i;
        rej_o = 1'b0;
        if (asleep_i) begin
            cmd_o = CMD_IDLE;
        end else if (recover_i && is_write(cmd_i)) begin
            cmd_o = CMD_IDLE;
            rej_o = 1'b1;
        end
    end

endmodule

// File: rtl/sleep_gate_ctrl.sv
`timescale 1ns/1ps
// Module: sleep_gate_ctrl (top)
// Synchronizes the sleep request, runs the entry delay and recovery window,
// and gates commands and output drivers. Memory contents are never touched.
// Assumes the request meets setup/hold at the first synchronizer flop, or
// that a one-cycle uncertainty in its recognition is acceptable.
module sleep_gate_ctrl #(
    parameter int SYNC_STAGES = 2,
    parameter int ENTRY_CYC   = 2,
    parameter int REC_CYC     = 3
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       sleep_req_i,
    input  logic [1:0] cmd_i,
    output logic [1:0] cmd_o,
    output logic       asleep_o,
    output logic       in_block_o,
    output logic       out_dis_o,
    output logic       cmd_rej_o
);

    logic req_sync;
    logic asleep;
    logic recover;

    slp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (sleep_req_i),
        .sync_o  (req_sync)
    );

    slp_fsm #(.ENTRY_CYC(ENTRY_CYC), .REC_CYC(REC_CYC)) u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .req_s_i   (req_sync),
        .asleep_o  (asleep),
        .recover_o (recover)
    );

    slp_cmd_filter u_filt (
        .asleep_i  (asleep),
        .recover_i (recover),
        .cmd_i     (cmd_i),
        .cmd_o     (cmd_o),
        .rej_o     (cmd_rej_o)
    );

    // Drive the sleep-phase control outputs.
    always_comb begin
        asleep_o   = asleep;
        in_block_o = asleep;
        out_dis_o  = asleep;
    end

endmodule

// File: rtl/slp_gate_checker.sv
`timescale 1ns/1ps
// Module: slp_gate_checker
// Temporal properties of the sleep guard, bound into sleep_gate_ctrl.
module slp_gate_checker (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       req_s,
    input logic [1:0] cmd_i,
    input logic [1:0] cmd_o,
    input logic       asleep_o,
    input logic       in_block_o,
    input logic       out_dis_o,
    input logic       cmd_rej_o
);

    p_asleep_blocks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        asleep_o |-> (in_block_o && out_dis_o && cmd_o == 2'b00));

    p_no_reject_asleep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        asleep_o |-> !cmd_rej_o);

    p_reject_only_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_rej_o |-> (cmd_i[1] && cmd_o == 2'b00));

    p_read_passes_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!asleep_o && cmd_i == 2'b01) |-> (cmd_o == 2'b01 && !cmd_rej_o));

    p_entry_needs_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(asleep_o) |-> $past(req_s));

    p_wake_needs_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(asleep_o) |-> !$past(req_s));

    p_write_blocked_on_wake_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(asleep_o) && cmd_i[1]) |-> cmd_rej_o);

endmodule

bind sleep_gate_ctrl slp_gate_checker u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_s      (req_sync),
    .cmd_i      (cmd_i),
    .cmd_o      (cmd_o),
    .asleep_o   (asleep_o),
    .in_block_o (in_block_o),
    .out_dis_o  (out_dis_o),
    .cmd_rej_o  (cmd_rej_o)
);

// File: tb/tb_sleep_gate_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expectations, the monitor pops and compares.
module tb_sleep_gate_ctrl;

    localparam int PH_AWAKE = 0;
    localparam int PH_SLEEP = 1;
    localparam int PH_REC   = 2;

    typedef struct {
        logic [5:0] exp;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0;
    logic [1:0] cmd = 2'b00;
    logic [1:0] cmd_out;
    logic       asleep, in_block, out_dis, rej;

    int    n_vec  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;
    item_t sb_q[$];

    always #4 clk = ~clk;

    sleep_gate_ctrl dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .sleep_req_i (req),
        .cmd_i       (cmd),
        .cmd_o       (cmd_out),
        .asleep_o    (asleep),
        .in_block_o  (in_block),
        .out_dis_o   (out_dis),
        .cmd_rej_o   (rej)
    );

    // Driver: one step per cycle; expectation built from the phase rules.
    task automatic step(input logic r, input logic [1:0] c, input int ph, input string tag);
        item_t it;
        logic [1:0] ec;
        logic er, es;
        @(negedge clk);
        req = r;
        cmd = c;
        es = (ph == PH_SLEEP);
        er = (ph == PH_REC) && c[1];
        ec = (es || er) ? 2'b00 : c;
        it.exp = {es, es, es, er, ec};
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compare in the low phase, after the driver has updated.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb_q.size() > 0) begin
                item_t it;
                logic [5:0] act;
                it  = sb_q.pop_front();
                act = {asleep, in_block, out_dis, rej, cmd_out};
                n_vec++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: {asleep,in_block,out_dis,rej,cmd}=%b expected %b",
                             it.tag, act, it.exp);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state; commands pass.
        step(1'b0, 2'b10, PH_AWAKE, "R1");
        step(1'b0, 2'b01, PH_AWAKE, "R1");
        step(1'b0, 2'b11, PH_AWAKE, "R1");
        @(negedge clk); rst_n = 1'b1;
        step(1'b0, 2'b00, PH_AWAKE, "R1");

        // R8: normal operation passes every code.
        for (int i = 0; i < 4; i++) step(1'b0, 2'(i), PH_AWAKE, "R8");

        // R2: entry latency; R8 writes pass during the entry delay.
        step(1'b1, 2'b01, PH_AWAKE, "R2");
        step(1'b1, 2'b10, PH_AWAKE, "R2");
        step(1'b1, 2'b11, PH_AWAKE, "R8");
        step(1'b1, 2'b10, PH_AWAKE, "R2");
        step(1'b1, 2'b10, PH_SLEEP, "R2");
        // R3: everything blocked while asleep.
        for (int i = 0; i < 4; i++) step(1'b1, 2'(i), PH_SLEEP, "R3");

        // R5: wake latency, then the recovery window.
        step(1'b0, 2'b10, PH_SLEEP, "R5");
        step(1'b0, 2'b11, PH_SLEEP, "R5");
        step(1'b0, 2'b01, PH_SLEEP, "R5");
        step(1'b0, 2'b10, PH_REC,   "R6");
        step(1'b0, 2'b11, PH_REC,   "R6");
        step(1'b0, 2'b01, PH_REC,   "R7");
        step(1'b0, 2'b10, PH_AWAKE, "R5");
        step(1'b0, 2'b11, PH_AWAKE, "R5");

        // R4: a short pulse aborts entry without recovery.
        step(1'b1, 2'b10, PH_AWAKE, "R4");
        for (int i = 0; i < 7; i++) step(1'b0, (i % 2 == 0) ? 2'b10 : 2'b11, PH_AWAKE, "R4");

        // R9: re-request inside recovery.
        step(1'b1, 2'b00, PH_AWAKE, "R2");
        for (int i = 0; i < 3; i++) step(1'b1, 2'b00, PH_AWAKE, "R2");
        step(1'b1, 2'b01, PH_SLEEP, "R3");
        step(1'b0, 2'b00, PH_SLEEP, "R5");
        step(1'b0, 2'b00, PH_SLEEP, "R5");
        step(1'b0, 2'b00, PH_SLEEP, "R5");
        step(1'b1, 2'b00, PH_REC,   "R7");
        step(1'b1, 2'b10, PH_REC,   "R9");
        step(1'b1, 2'b11, PH_REC,   "R9");
        step(1'b1, 2'b10, PH_AWAKE, "R9");
        step(1'b1, 2'b10, PH_AWAKE, "R9");
        step(1'b1, 2'b10, PH_SLEEP, "R9");

        // Final wake and full recovery.
        step(1'b0, 2'b01, PH_SLEEP, "R5");
        step(1'b0, 2'b01, PH_SLEEP, "R5");
        step(1'b0, 2'b01, PH_SLEEP, "R5");
        step(1'b0, 2'b11, PH_REC,   "R6");
        step(1'b0, 2'b00, PH_REC,   "R7");
        step(1'b0, 2'b10, PH_REC,   "R6");
        step(1'b0, 2'b10, PH_AWAKE, "R5");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule